// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides whether a branch in a simple in-order core is taken and where it goes. It holds three architectural registers: a condition register made of eight 4-bit fields, a loop count register and a link register. A compare port writes the outcome of a signed or unsigned comparison into one selected field. The other fields are left alone, so several results can be held at once.

A branch port takes an already decoded descriptor. In the same cycle the block returns the taken decision and the target address. On the next clock edge it applies the register updates the branch asks for. A single branch can decrement the count register and test the decremented value against zero. It can test any one condition bit against a required level and combine the two tests. It can take its target from the link or count register while also writing a new return address into the link register. Two write ports let the core load the count and link registers directly.

Top module: `branch_resolve_unit`

## Requirements
- R1: After a synchronous active-low reset, the condition, count and link registers read zero and `br_taken` is 0.
- R2: A compare with `cmp_valid` high writes field `cmp_field` of `cr_q` on the next edge. Field f occupies flat bits 4f (less-than), 4f+1 (greater-than), 4f+2 (equal) and 4f+3 (summary-overflow). Exactly one of the first three bits is set, from a signed (`cmp_signed`=1) or unsigned comparison of `cmp_a` against `cmp_b`. The summary-overflow bit copies `cmp_so_in`.
- R3: A compare leaves every field other than the selected one unchanged. With no compare, `cr_q` holds its value.
- R4: With `br_ctr_dec`=1, a valid branch lowers the count register by one, wrapping from 0 to all ones. The count test uses the decremented value, or the current value when no decrement is requested. The test passes when (value == 0) equals `br_ctr_zero`, or always when `br_ctr_ignore`=1.
- R5: The bit test passes when `cr_q[br_bit_idx]` equals `br_bit_want`, or always when `br_bit_ignore`=1. Flat index 0 is field 0 less-than and index 31 is field 7 summary-overflow. `br_taken` is 1 only when `br_valid` is 1 and both tests pass.
- R6: `br_target` is combinational from the descriptor. Selector 0 gives `br_imm` with bits 1:0 cleared. Selector 1 gives `br_pc + br_imm` with bits 1:0 cleared. Selector 2 gives the link register. Selector 3 gives the count register value before any decrement by this branch.
- R7: With `br_link`=1, a valid branch writes `br_pc + 4` into the link register on the next edge. A branch that both targets the link register and writes it uses the old link value as its target.
- R8: `ctr_wr_en` and `lr_wr_en` load `ctr_wr_data` and `lr_wr_data` on the next edge. Each takes priority over a branch update to the same register in that cycle.
- R9: The count and link updates of a valid branch happen whether or not it is taken. A branch evaluates the condition register as it stood before a compare issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | Compare request |
| cmp_field | input | 3 | Condition field to write |
| cmp_signed | input | 1 | 1 = signed comparison, 0 = unsigned |
| cmp_a | input | 32 | Left compare operand |
| cmp_b | input | 32 | Right compare operand |
| cmp_so_in | input | 1 | Sticky overflow copied into the field |
| ctr_wr_en | input | 1 | Direct load of the count register |
| ctr_wr_data | input | 32 | Count load value |
| lr_wr_en | input | 1 | Direct load of the link register |
| lr_wr_data | input | 32 | Link load value |
| br_valid | input | 1 | Branch descriptor present |
| br_pc | input | 32 | Address of the branch |
| br_imm | input | 32 | Absolute or relative immediate |
| br_bit_idx | input | 5 | Flat condition bit index |
| br_bit_ignore | input | 1 | Skip the bit test |
| br_bit_want | input | 1 | Required bit level |
| br_ctr_dec | input | 1 | Decrement count before testing |
| br_ctr_ignore | input | 1 | Skip the count test |
| br_ctr_zero | input | 1 | 1 = pass on zero, 0 = pass on nonzero |
| br_tgt_sel | input | 2 | Target source: 0 absolute, 1 relative, 2 link, 3 count |
| br_link | input | 1 | Write return address to link |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Branch target address |
| cr_q | output | 32 | Condition register |
| ctr_q | output | 32 | Count register |
| lr_q | output | 32 | Link register |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and operands and eight condition fields. These values make every flat bit index from 0 to 31 reachable, including both ends, as well as the wrap of the count register from zero to all ones. Small random operand and count ranges make equal compares and zero counts frequent. Directed cases cover a load colliding with a decrement, a branch that reads and rewrites the link register, and a compare and a branch issued in the same cycle.

// File: rtl/brc_pkg.sv
// Shared definitions for the branch resolution unit.
// Assumes a condition field is four bits wide: less-than, greater-than, equal, overflow.
package brc_pkg;
    localparam int FIELD_W = 4;
    localparam int LT_POS  = 0;
    localparam int GT_POS  = 1;
    localparam int EQ_POS  = 2;
    localparam int SO_POS  = 3;

    typedef enum logic [1:0] {
        TGT_ABS   = 2'd0,
        TGT_REL   = 2'd1,
        TGT_LINK  = 2'd2,
        TGT_COUNT = 2'd3
    } tgt_sel_e;
endpackage

// File: rtl/brc_compare.sv
// Produces one 4-bit condition field from two operands.
// Assumes a purely combinational use; the caller registers the result.
module brc_compare
    import brc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]    a,
    input  logic [XLEN-1:0]    b,
    input  logic               is_signed,
    input  logic               so_in,
    output logic [FIELD_W-1:0] field
);
    logic lt, eq;

    // Form exactly one relation bit plus the copied overflow bit.
    always_comb begin
        lt = is_signed ? ($signed(a) < $signed(b)) : (a < b);
        eq = (a == b);
        field         = '0;
        field[LT_POS] = lt;
        field[EQ_POS] = eq;
        field[GT_POS] = !lt && !eq;
        field[SO_POS] = so_in;
    end
endmodule

// File: rtl/brc_cond_bank.sv
// Condition register built from NFIELD independent 4-bit fields.
// Assumes NFIELD >= 2 and at most one field write per cycle.
module brc_cond_bank
    import brc_pkg::*;
#(
    parameter int NFIELD = 8,
    localparam int SEL_W = $clog2(NFIELD),
    localparam int CR_W  = NFIELD * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [FIELD_W-1:0] wr_field,
    output logic [CR_W-1:0]    cr_q
);
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        logic [FIELD_W-1:0] f_q;
        // Hold one field; load it only when it is the selected one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                f_q <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                f_q <= wr_field;
        end
        assign cr_q[g*FIELD_W +: FIELD_W] = f_q;
    end

    logic [CR_W-1:0] wr_mask;
    // Mark the bits a write may touch, for the checks below.
    always_comb begin
        wr_mask = '0;
        wr_mask[wr_sel*FIELD_W +: FIELD_W] = {FIELD_W{1'b1}};
    end

    // R3: fields outside the selected one keep their value.
    assert_other_fields_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cr_q & ~$past(wr_mask)) == ($past(cr_q) & ~$past(wr_mask))));
    // R3: no write, no change.
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cr_q));
    // R2: an incoming field carries exactly one relation.
    assert_one_relation_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $countones(wr_field[EQ_POS:LT_POS]) == 1);
endmodule

// File: rtl/brc_branch_eval.sv
// Evaluates the count and bit tests of a branch and selects its target.
// Assumes register state is sampled before this cycle's updates.
module brc_branch_eval
    import brc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CR_W = 32,
    localparam int IDX_W = $clog2(CR_W)
) (
    input  logic             valid,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  imm,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_ignore,
    input  logic             bit_want,
    input  logic             ctr_dec,
    input  logic             ctr_ignore,
    input  logic             ctr_zero,
    input  tgt_sel_e         tgt_sel,
    input  logic [CR_W-1:0]  cr,
    input  logic [XLEN-1:0]  ctr,
    input  logic [XLEN-1:0]  lr,
    output logic             taken,
    output logic [XLEN-1:0]  target,
    output logic [XLEN-1:0]  ctr_next,
    output logic [XLEN-1:0]  link_val
);
    localparam logic [XLEN-1:0] ALIGN = {{(XLEN-2){1'b1}}, 2'b00};
    logic ctr_ok, bit_ok;

    // Combine the pre-decremented count test with the single-bit test.
    always_comb begin
        ctr_next = ctr_dec ? ctr - XLEN'(1) : ctr;
        ctr_ok   = ctr_ignore || ((ctr_next == '0) == ctr_zero);
        bit_ok   = bit_ignore || (cr[bit_idx] == bit_want);
        taken    = valid && ctr_ok && bit_ok;
        link_val = pc + XLEN'(4);
    end

    // Pick the target from the immediate, the pc, or a register's old value.
    always_comb begin
        unique case (tgt_sel)
            TGT_ABS:   target = imm & ALIGN;
            TGT_REL:   target = (pc + imm) & ALIGN;
            TGT_LINK:  target = lr;
            default:   target = ctr;
        endcase
    end
endmodule

// File: rtl/branch_resolve_unit.sv
// Branch resolution unit: condition, count and link registers with a compare
// port and a branch port. Decision and target are combinational; register
// updates land on the next edge. Direct loads override branch updates.
module branch_resolve_unit
    import brc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NFIELD = 8,
    localparam int SEL_W = $clog2(NFIELD),
    localparam int CR_W  = NFIELD * FIELD_W,
    localparam int IDX_W = $clog2(CR_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic [SEL_W-1:0] cmp_field,
    input  logic             cmp_signed,
    input  logic [XLEN-1:0]  cmp_a,
    input  logic [XLEN-1:0]  cmp_b,
    input  logic             cmp_so_in,
    input  logic             ctr_wr_en,
    input  logic [XLEN-1:0]  ctr_wr_data,
    input  logic             lr_wr_en,
    input  logic [XLEN-1:0]  lr_wr_data,
    input  logic             br_valid,
    input  logic [XLEN-1:0]  br_pc,
    input  logic [XLEN-1:0]  br_imm,
    input  logic [IDX_W-1:0] br_bit_idx,
    input  logic             br_bit_ignore,
    input  logic             br_bit_want,
    input  logic             br_ctr_dec,
    input  logic             br_ctr_ignore,
    input  logic             br_ctr_zero,
    input  logic [1:0]       br_tgt_sel,
    input  logic             br_link,
    output logic             br_taken,
    output logic [XLEN-1:0]  br_target,
    output logic [CR_W-1:0]  cr_q,
    output logic [XLEN-1:0]  ctr_q,
    output logic [XLEN-1:0]  lr_q
);
    logic [FIELD_W-1:0] cmp_res;
    logic [XLEN-1:0]    ctr_next, link_val;

    brc_compare #(.XLEN(XLEN)) cmp_i (
        .a(cmp_a), .b(cmp_b), .is_signed(cmp_signed),
        .so_in(cmp_so_in), .field(cmp_res)
    );

    brc_cond_bank #(.NFIELD(NFIELD)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cmp_valid),
        .wr_sel(cmp_field), .wr_field(cmp_res), .cr_q(cr_q)
    );

    brc_branch_eval #(.XLEN(XLEN), .CR_W(CR_W)) eval_i (
        .valid(br_valid), .pc(br_pc), .imm(br_imm),
        .bit_idx(br_bit_idx), .bit_ignore(br_bit_ignore), .bit_want(br_bit_want),
        .ctr_dec(br_ctr_dec), .ctr_ignore(br_ctr_ignore), .ctr_zero(br_ctr_zero),
        .tgt_sel(tgt_sel_e'(br_tgt_sel)), .cr(cr_q), .ctr(ctr_q), .lr(lr_q),
        .taken(br_taken), .target(br_target), .ctr_next(ctr_next), .link_val(link_val)
    );

    // Count register: direct load first, then a branch decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctr_q <= '0;
        else if (ctr_wr_en)
            ctr_q <= ctr_wr_data;
        else if (br_valid && br_ctr_dec)
            ctr_q <= ctr_next;
    end

    // Link register: direct load first, then a branch return address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lr_q <= '0;
        else if (lr_wr_en)
            lr_q <= lr_wr_data;
        else if (br_valid && br_link)
            lr_q <= link_val;
    end

    // R7: a linking branch leaves its successor address behind.
    assert_link_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && br_link && !lr_wr_en |=> lr_q == $past(br_pc) + XLEN'(4));
    // R4: a decrementing branch lowers the count by one.
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && br_ctr_dec && !ctr_wr_en |=> ctr_q == $past(ctr_q) - XLEN'(1));
    // R5: no descriptor, no taken branch.
    assert_idle_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |-> !br_taken);
    // R6: immediate-based targets are word aligned.
    assert_aligned_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && !br_tgt_sel[1] |-> br_target[1:0] == 2'b00);
    // R8: a direct count load wins.
    assert_count_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_wr_en |=> ctr_q == $past(ctr_wr_data));
    // R7: a branch through the link register uses the value held before the write.
    assert_link_target_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && br_tgt_sel == 2'd2 |-> br_target == lr_q);
endmodule

// File: tb/branch_resolve_unit_tb_top.sv
`timescale 1ns/1ps
module branch_resolve_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cmp_valid, cmp_signed, cmp_so_in;
    logic [2:0]  cmp_field;
    logic [31:0] cmp_a, cmp_b;
    logic        ctr_wr_en, lr_wr_en;
    logic [31:0] ctr_wr_data, lr_wr_data;
    logic        br_valid, br_bit_ignore, br_bit_want, br_ctr_dec, br_ctr_ignore;
    logic        br_ctr_zero, br_link;
    logic [31:0] br_pc, br_imm;
    logic [4:0]  br_bit_idx;
    logic [1:0]  br_tgt_sel;
    logic        br_taken;
    logic [31:0] br_target, cr_q, ctr_q, lr_q;

    branch_resolve_unit dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_cr = '0, m_ctr = '0, m_lr = '0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] f_cmp(logic [31:0] a, logic [31:0] b, logic sg, logic so);
        logic lt;
        lt = sg ? ($signed(a) < $signed(b)) : (a < b);
        return {so, a == b, (!lt && a != b), lt};
    endfunction

    task automatic idle();
        cmp_valid = 0; cmp_signed = 0; cmp_so_in = 0; cmp_field = 0; cmp_a = 0; cmp_b = 0;
        ctr_wr_en = 0; ctr_wr_data = 0; lr_wr_en = 0; lr_wr_data = 0;
        br_valid = 0; br_pc = 0; br_imm = 0; br_bit_idx = 0; br_bit_ignore = 1;
        br_bit_want = 0; br_ctr_dec = 0; br_ctr_ignore = 1; br_ctr_zero = 0;
        br_tgt_sel = 0; br_link = 0;
    endtask

    // One cycle: check combinational outputs, then registered state after the edge.
    task automatic run_cycle(string tag);
        logic [31:0] cv, t, n_cr, n_ctr, n_lr;
        logic tk;
        #1;
        cv = br_ctr_dec ? m_ctr - 1 : m_ctr;
        tk = br_valid && (br_ctr_ignore || ((cv == 0) == br_ctr_zero))
                      && (br_bit_ignore || (m_cr[br_bit_idx] == br_bit_want));
        case (br_tgt_sel)
            2'd0: t = br_imm & 32'hFFFF_FFFC;
            2'd1: t = (br_pc + br_imm) & 32'hFFFF_FFFC;
            2'd2: t = m_lr;
            default: t = m_ctr;
        endcase
        check({tag, " R5 taken"}, {31'd0, br_taken}, {31'd0, tk});
        if (br_valid) check({tag, " R6 target"}, br_target, t);
        n_cr = m_cr;
        if (cmp_valid) n_cr[cmp_field*4 +: 4] = f_cmp(cmp_a, cmp_b, cmp_signed, cmp_so_in);
        n_ctr = ctr_wr_en ? ctr_wr_data : ((br_valid && br_ctr_dec) ? cv : m_ctr);
        n_lr  = lr_wr_en ? lr_wr_data : ((br_valid && br_link) ? br_pc + 4 : m_lr);
        @(posedge clk);
        #1;
        m_cr = n_cr; m_ctr = n_ctr; m_lr = n_lr;
        check({tag, " R2 R3 cr"}, cr_q, m_cr);
        check({tag, " R4 R8 ctr"}, ctr_q, m_ctr);
        check({tag, " R7 R8 lr"}, lr_q, m_lr);
        @(negedge clk);
        idle();
    endtask

    task automatic branch(logic [31:0] pc, logic [31:0] imm, logic [1:0] sel, logic [4:0] idx,
                          logic bign, logic bwant, logic dec, logic cign, logic czero, logic lnk);
        br_valid = 1; br_pc = pc; br_imm = imm; br_tgt_sel = sel; br_bit_idx = idx;
        br_bit_ignore = bign; br_bit_want = bwant; br_ctr_dec = dec;
        br_ctr_ignore = cign; br_ctr_zero = czero; br_link = lnk;
    endtask

    task automatic compare(logic [2:0] f, logic sg, logic [31:0] a, logic [31:0] b, logic so);
        cmp_valid = 1; cmp_field = f; cmp_signed = sg; cmp_a = a; cmp_b = b; cmp_so_in = so;
    endtask

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0042);
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        check("R1 cr", cr_q, 0);
        check("R1 ctr", ctr_q, 0);
        check("R1 lr", lr_q, 0);
        check("R1 taken", {31'd0, br_taken}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2: signed -1 < 1 into field 3, unsigned gives greater-than into field 5.
        compare(3'd3, 1, 32'hFFFF_FFFF, 32'd1, 0); run_cycle("R2 signed lt");
        compare(3'd5, 0, 32'hFFFF_FFFF, 32'd1, 1); run_cycle("R2 R3 unsigned gt so");
        compare(3'd0, 1, 32'd20, 32'd20, 0);       run_cycle("R2 R3 equal");
        compare(3'd7, 0, 32'd0, 32'd0, 1);         run_cycle("R2 field7");
        check("R5 idx31 set", {31'd0, cr_q[31]}, 1);
        check("R2 field0 eq", {28'd0, cr_q[3:0]}, 32'h4);

        // R5: flat index 0 and 31 tests.
        branch(32'h100, 32'h40, 2'd0, 5'd31, 0, 1, 0, 1, 0, 0); run_cycle("R5 idx31 want1");
        branch(32'h100, 32'h40, 2'd0, 5'd0, 0, 1, 0, 1, 0, 0);  run_cycle("R5 idx0 want1");
        branch(32'h100, 32'h40, 2'd0, 5'd0, 0, 0, 0, 1, 0, 0);  run_cycle("R5 idx0 want0");

        // R4: count loop and wrap from zero.
        ctr_wr_en = 1; ctr_wr_data = 2; run_cycle("R8 load");
        branch(32'h200, 32'hFFFF_FFF3, 2'd1, 5'd0, 1, 0, 1, 0, 0, 0); run_cycle("R4 R6 dnz taken");
        branch(32'h200, 32'hFFFF_FFF3, 2'd1, 5'd0, 1, 0, 1, 0, 0, 0); run_cycle("R4 dnz fall");
        branch(32'h200, 32'h0, 2'd3, 5'd0, 1, 0, 1, 0, 1, 0);         run_cycle("R4 R6 wrap");
        check("R4 wrapped", ctr_q, 32'hFFFF_FFFF);

        // R7: link target uses old link while link is rewritten.
        lr_wr_en = 1; lr_wr_data = 32'h0000_3000; run_cycle("R8 lr load");
        branch(32'h400, 32'h0, 2'd2, 5'd0, 1, 0, 0, 1, 0, 1); run_cycle("R7 link swap");
        check("R7 new link", lr_q, 32'h404);

        // R8: load beats decrement in the same cycle.
        ctr_wr_en = 1; ctr_wr_data = 32'd9;
        branch(32'h500, 32'h0, 2'd0, 5'd0, 1, 0, 1, 0, 0, 0); run_cycle("R8 load wins");
        check("R8 ctr loaded", ctr_q, 32'd9);

        // R9: untaken branch still updates; branch sees CR before same-cycle compare.
        branch(32'h600, 32'h0, 2'd0, 5'd9, 0, 1, 1, 1, 0, 1);
        compare(3'd2, 0, 32'd5, 32'd2, 0); run_cycle("R9 old cr");
        check("R9 lr untaken", lr_q, 32'h604);
        check("R9 ctr untaken", ctr_q, 32'd8);

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 2) == 0)
                compare(3'($urandom_range(0, 7)), 1'($urandom), $urandom_range(0, 6) - 3,
                        $urandom_range(0, 6) - 3, 1'($urandom));
            if ($urandom_range(0, 5) == 0) begin ctr_wr_en = 1; ctr_wr_data = $urandom_range(0, 3); end
            if ($urandom_range(0, 7) == 0) begin lr_wr_en = 1; lr_wr_data = $urandom; end
            if ($urandom_range(0, 1) == 0)
                branch($urandom, $urandom, 2'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            run_cycle("random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule